// File: doc/BRIEF.md
# Bus Ownership Arbiter with Operand Coherency

This block decides who drives the system bus: the on-chip processor or a single external master. The external master raises a request, receives a grant, and answers with an acknowledge once it has taken the bus. The external request always wins over the processor. The grant is still held back until the processor's current operand has finished all of its bus cycles and no read-modify-write lock is active. A longword moved through a byte-wide port therefore stays in one piece, and so does an indivisible test-and-set pair. Separate operands of a multi-operand transfer may still be interleaved with external ownership.

The processor side reports the start of each operand, together with the number of bus cycles it needs. It also gives a strobe for each terminated bus cycle and a level-sensitive lock. The processor may start a new operand only while `cpu_bus_ok` is high. During the first cycle of a grant, the arbiter drives the address and control outputs high for one cycle. It then releases them to high impedance. A grant-low counter enforces a minimum number of cycles between successive grants.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, `bus_grant` is 0, `cpu_bus_ok` is 1, `drive_en` is 1 and `drive_high` is 0.
- R2: With no operand in progress and no lock, a request sampled at a clock edge gives `bus_grant` = 1 and `cpu_bus_ok` = 0 right after that edge.
- R3: The first grant cycle is a pre-drive cycle with `drive_en` = 1 and `drive_high` = 1. In the next cycle `drive_en` = 0 and `drive_high` = 0, and `bus_grant` stays 1.
- R4: A sampled `op_start` with `op_len` = N (1..MAX_CYC) holds off the grant until N `cyc_done` strobes have been sampled. The grant rises right after the edge that samples the last strobe, if a request is pending at that edge.
- R5: No grant rises after an edge that sampled `rmw_lock` = 1.
- R6: Between two operands (count at zero, lock low), a pending request is granted even though the processor has more operands to move.
- R7: After the pre-drive cycle, an edge that samples `ext_ack` = 1 makes `bus_grant` = 0 right after that edge.
- R8: While the external master owns the bus, the first edge that samples both `ext_req` = 0 and `ext_ack` = 0 gives `cpu_bus_ok` = 1 and `drive_en` = 1 right after it.
- R9: If the request is sampled low after the pre-drive cycle, before any acknowledge, `bus_grant` drops right after that edge. The processor regains the bus through the same path as in R8.
- R10: Once `bus_grant` falls, it stays 0 for at least MIN_LOW cycles (default 2).
- R11: `op_start` while `cpu_bus_ok` = 0 is ignored, and so is `cyc_done` with no operand counted. Neither one delays a later grant.
- R12: `cpu_bus_ok` = (processor owns the bus) AND (`ext_req` = 0 OR `rmw_lock` = 1). This is how the external request gets priority and a locked sequence can finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | 1 | External master bus request, active high |
| ext_ack | input | 1 | External master grant acknowledge, active high |
| op_start | input | 1 | Processor begins an operand transfer this cycle |
| op_len | input | $clog2(MAX_CYC+1) | Number of bus cycles of the starting operand |
| cyc_done | input | 1 | One processor bus cycle terminates this cycle |
| rmw_lock | input | 1 | Read-modify-write sequence in progress |
| bus_grant | output | 1 | Grant to the external master |
| cpu_bus_ok | output | 1 | Processor may start an operand |
| drive_en | output | 1 | Output enable for address and control pins |
| drive_high | output | 1 | Drive address and control pins high (pre-release) |

## Verification
The remaining-cycle count of the current operand is hidden state. A wrong count shows at the ports as a grant that comes one or more cycles early, in the middle of an operand, or one that waits for strobes that never come. In both cases the grant edge moves relative to the last `cyc_done`, and a cycle-exact reference catches this in the cycle it happens. A wrong ownership state appears within one cycle as a bad combination of `drive_en`, `drive_high`, `bus_grant` and `cpu_bus_ok`. A broken grant-low counter appears as a re-grant that comes too soon after a fall. Random request, acknowledge, lock and strobe traffic is mixed with directed sequences for four-cycle operands, locks, withdrawal and immediate re-request.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int MAX_CYC = 4,
  parameter int MIN_LOW = 2,
  localparam int CW = $clog2(MAX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_req,
  input  logic          ext_ack,
  input  logic          op_start,
  input  logic [CW-1:0] op_len,
  input  logic          cyc_done,
  input  logic          rmw_lock,
  output logic          bus_grant,
  output logic          cpu_bus_ok,
  output logic          drive_en,
  output logic          drive_high
);

  localparam int LW = $clog2(MIN_LOW + 1);

  typedef enum logic [1:0] {S_CPU, S_PRE, S_GNT, S_EXT} st_t;

  st_t           st_q, st_d;
  logic [CW-1:0] rem_q;
  logic [LW-1:0] lo_q;
  logic          idle_now, lo_ok, take;

  assign idle_now   = (rem_q == '0) || ((rem_q == CW'(1)) && cyc_done);
  assign lo_ok      = (int'(lo_q) + 1) >= MIN_LOW;
  assign take       = (st_q == S_CPU) && ext_req && !rmw_lock && idle_now && lo_ok;

  assign bus_grant  = (st_q == S_PRE) || (st_q == S_GNT);
  assign cpu_bus_ok = (st_q == S_CPU) && (!ext_req || rmw_lock);
  assign drive_en   = (st_q == S_CPU) || (st_q == S_PRE);
  assign drive_high = (st_q == S_PRE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_CPU: if (take) st_d = S_PRE;
      S_PRE: st_d = S_GNT;
      S_GNT: if (ext_ack || !ext_req) st_d = S_EXT;
      S_EXT: if (!ext_ack && !ext_req) st_d = S_CPU;
      default: st_d = S_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_CPU;
      rem_q <= '0;
      lo_q  <= LW'(MIN_LOW);
    end else begin
      st_q <= st_d;
      if (op_start && cpu_bus_ok)
        rem_q <= op_len;
      else if (cyc_done && rem_q != '0)
        rem_q <= rem_q - CW'(1);
      if (bus_grant)
        lo_q <= '0;
      else if (int'(lo_q) < MIN_LOW)
        lo_q <= lo_q + LW'(1);
    end
  end

  // R3
  predrive_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> (drive_high && drive_en));

  // R3
  predrive_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_high |=> (bus_grant && !drive_en && !drive_high));

  // R4
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && rem_q > CW'(1)) |=> !bus_grant);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && rmw_lock) |=> !bus_grant);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !drive_en && ext_ack) |=> !bus_grant);

  // R8
  regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && !drive_en && !ext_ack && !ext_req) |=> (drive_en && !bus_grant));

  // R12
  owner_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_bus_ok |-> (drive_en && !drive_high && !bus_grant));

  generate
    if (MIN_LOW >= 2) begin : g_low
      // R10
      low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant) |=> !bus_grant);
    end
  endgenerate

endmodule

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
  localparam int MAX_CYC = 4;
  localparam int MIN_LOW = 2;
  localparam int CW = $clog2(MAX_CYC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req = 0, ext_ack = 0, op_start = 0, cyc_done = 0, rmw_lock = 0;
  logic [CW-1:0] op_len = '0;
  logic bus_grant, cpu_bus_ok, drive_en, drive_high;

  int checks = 0;
  int failures = 0;
  int m_st = 0;
  int m_rem = 0;
  int m_lo = MIN_LOW;

  always #10 clk = ~clk;

  bus_arbiter #(.MAX_CYC(MAX_CYC), .MIN_LOW(MIN_LOW)) u_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_ack(ext_ack),
    .op_start(op_start), .op_len(op_len), .cyc_done(cyc_done),
    .rmw_lock(rmw_lock), .bus_grant(bus_grant), .cpu_bus_ok(cpu_bus_ok),
    .drive_en(drive_en), .drive_high(drive_high));

  function automatic logic exp_grant(int s);
    return (s == 1) || (s == 2);
  endfunction

  function automatic logic exp_ok(int s, logic rq, logic lk);
    return (s == 0) && (!rq || lk);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic ok, idle, take;
    int nst;
    ok   = exp_ok(m_st, ext_req, rmw_lock);
    idle = (m_rem == 0) || (m_rem == 1 && cyc_done);
    take = (m_st == 0) && ext_req && !rmw_lock && idle && (m_lo + 1 >= MIN_LOW);
    nst  = m_st;
    case (m_st)
      0: if (take) nst = 1;
      1: nst = 2;
      2: if (ext_ack || !ext_req) nst = 3;
      default: if (!ext_ack && !ext_req) nst = 0;
    endcase
    if (op_start && ok) m_rem = int'(op_len);
    else if (cyc_done && m_rem != 0) m_rem = m_rem - 1;
    if (exp_grant(m_st)) m_lo = 0;
    else if (m_lo < MIN_LOW) m_lo = m_lo + 1;
    m_st = nst;
  endtask

  task automatic cmp_all();
    chk("R7 grant-vs-model", bus_grant, exp_grant(m_st));
    chk("R12 cpu_ok-vs-model", cpu_bus_ok, exp_ok(m_st, ext_req, rmw_lock));
    chk("R8 drive_en-vs-model", drive_en, (m_st == 0) || (m_st == 1));
    chk("R3 drive_high-vs-model", drive_high, m_st == 1);
  endtask

  task automatic cyc(logic rq, logic ak, logic st, logic dn, logic lk, int ln);
    ext_req = rq; ext_ack = ak; op_start = st; cyc_done = dn; rmw_lock = lk;
    op_len = CW'(ln);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic rq, lk;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 grant", bus_grant, 1'b0);
    chk("R1 cpu_ok", cpu_bus_ok, 1'b1);
    chk("R1 drive_en", drive_en, 1'b1);
    chk("R1 drive_high", drive_high, 1'b0);

    // R2/R3 best case, then R7 and R8
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 grant", bus_grant, 1'b1);
    chk("R2 cpu_ok", cpu_bus_ok, 1'b0);
    chk("R3 predrive", drive_high & drive_en, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R3 released", drive_en | drive_high, 1'b0);
    chk("R3 grant held", bus_grant, 1'b1);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R7 grant off", bus_grant, 1'b0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R8 still ext", drive_en, 1'b0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8 regain ok", cpu_bus_ok, 1'b1);
    chk("R8 regain en", drive_en, 1'b1);

    // R4 four-cycle operand
    cyc(0, 0, 1, 0, 0, 4);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 wait0", bus_grant, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 1, 0, 0);
      chk("R4 mid-operand", bus_grant, 1'b0);
    end
    cyc(1, 0, 0, 1, 0, 0);
    chk("R4 grant after last", bus_grant, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // R5 lock, R12 priority under lock
    cyc(0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 1, 1, 0);
    cyc(1, 0, 0, 0, 1, 0);
    chk("R5 locked", bus_grant, 1'b0);
    chk("R12 lock keeps cpu", cpu_bus_ok, 1'b1);
    cyc(1, 0, 0, 0, 1, 0);
    chk("R5 locked2", bus_grant, 1'b0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R12 req blocks cpu", cpu_bus_ok, 1'b0);
    chk("R5 unlock grant", bus_grant, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    // R11 op_start during external ownership ignored
    cyc(0, 1, 1, 0, 0, 4);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R11 ignored start", bus_grant, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    // R9 withdraw, R10 minimum low
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 withdrawn", bus_grant, 1'b0);
    chk("R9 not yet cpu", cpu_bus_ok, 1'b0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R10 low hold", bus_grant, 1'b0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 cpu back", cpu_bus_ok, 1'b1);
    chk("R10 low2", bus_grant, 1'b0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R10 regrant", bus_grant, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // R6 between operands, R11 stray cyc_done
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0, 1);
    cyc(1, 0, 0, 1, 0, 0);
    chk("R6 between operands", bus_grant, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // random traffic against the model
    rq = 0; lk = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) rq = ~rq;
      if ($urandom_range(0, 9) == 0) lk = ~lk;
      cyc(rq, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
          ($urandom_range(0, 1) == 0), lk, $urandom_range(1, MAX_CYC));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule